// File: doc/BRIEF.md
# CAN Error Interrupt and Code Capture

This block sits between a CAN protocol engine and the software-visible register file of a CAN controller. The engine reports eight classes of fault as single-cycle pulses, protocol error types as a second set of pulses, and its live transmit and receive error counts. The block latches each fault class into a sticky flag and gates the flags with a matching enable register. It captures error types into an error code register and holds both error counts for readout. It also raises one combined error interrupt.

Software clears flags by writing the complement of the bit it wants to clear. A written 0 clears the bit and a written 1 leaves it alone, so other flags that are being set at the same moment are never lost. The error code register has two capture styles, chosen by its top bit. It either gathers every error type seen since the last clear, or keeps only the types of the most recent error. Writes and reads use a small register port: writes take effect at the clock edge, and reads are combinational from the held state.

Top module: `can_err_capture`

## Requirements
- R1: Fault pulse input bit i sets flag bit i (address 0), which then holds until software clears it. Bit order from 7 down to 0 is: bus lock, overload frame, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error.
- R2: A write to address 0 clears every flag bit written as 0 and leaves every flag bit written as 1 unchanged.
- R3: When a fault pulse and a clearing write hit the same flag bit in one cycle, the bit ends up set.
- R4: The flag enable register (address 1) uses the same bit layout as the flags, is read/write, and a write replaces it.
- R5: Bit 7 of the error code register (address 2) is the capture mode and is read/write: 1 = accumulate, 0 = latest only. Bits 6 to 0 are ACK delimiter error, dominant bit error, recessive bit error, CRC error, ACK error, form error and stuff error, driven by code pulse input bits 6 to 0.
- R6: In accumulate mode, code pulses OR into bits 6 to 0. A write to address 2 clears each code bit written as 0 unless that bit's pulse arrives in the same cycle.
- R7: In latest-only mode, any nonzero code pulse replaces bits 6 to 0 with exactly the pulse bits, and a write in that cycle does not clear them. With no pulse, writes clear bits as in R6. The mode used in a cycle is the one held before that cycle's write.
- R8: Address 3 reads the transmit error count and address 4 the receive error count, each as sampled at the previous clock edge. Writes to them have no effect.
- R9: Address 5 reads the interrupt status. Bit 5 is 1 exactly when the bitwise AND of flags and enables is nonzero, and all other bits read 0. The register is read-only.
- R10: Address 6 holds the interrupt enable, and only bit 5 is stored. The output err_irq_o is 1 exactly when status bit 5 and enable bit 5 are both 1.
- R11: After reset every register reads 0 and err_irq_o is 0. Address 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fault_evt_i | input | 8 | Fault class pulses, one bit per flag |
| code_evt_i | input | 7 | Error type pulses for the code register |
| tx_cnt_i | input | 8 | Live transmit error count from the engine |
| rx_cnt_i | input | 8 | Live receive error count from the engine |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Combinational read data |
| err_irq_o | output | 1 | Combined error interrupt request |

## Verification
On every cycle, assertions check that a pulsed flag or code bit is set in the next cycle, and that no flag rises without a pulse. They also check that latest-only capture holds exactly the new pulse bits, that the held counts follow their inputs by one cycle, and that the interrupt never fires without an enabled flag and its enable bit. Only the bench's scenarios can show the full value after a partial clear and the switching between capture modes. The same holds for the reset contents of every address, the read-only behaviour of the count and status addresses, and a random mix of writes and pulses compared against a reference model.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int DW     = 8;
  localparam int AW     = 3;
  localparam int NFLAG  = 8;
  localparam int NCODE  = 7;
  localparam int IRQ_BIT = 5;

  localparam logic [AW-1:0] A_FLAG  = 3'd0;
  localparam logic [AW-1:0] A_FEN   = 3'd1;
  localparam logic [AW-1:0] A_CODE  = 3'd2;
  localparam logic [AW-1:0] A_TXCNT = 3'd3;
  localparam logic [AW-1:0] A_RXCNT = 3'd4;
  localparam logic [AW-1:0] A_ISTAT = 3'd5;
  localparam logic [AW-1:0] A_IEN   = 3'd6;
endpackage

// File: rtl/cec_w0c_bank.sv
// Sticky flag bank: pulse sets, written zero clears, set has priority.
module cec_w0c_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_n;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic keep;
    always_comb begin
      keep   = wr_i ? (q_o[i] & wdata_i[i]) : q_o[i];
      q_n[i] = set_i[i] | keep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[i] <= 1'b0;
      else        q_o[i] <= q_n[i];
    end
  end

  // R3: a pulsed bit is set afterwards, whatever was written
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R2: no bit rises without its pulse
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & ~$past(q_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/cec_code_capture.sv
// Error code register: mode bit plus error type bits.
module cec_code_capture #(
  parameter int NC = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [NC-1:0] evt_i,
  input  logic        wr_i,
  input  logic [NC:0] wdata_i,
  output logic [NC:0] code_o
);
  logic          mode_q, mode_n;
  logic [NC-1:0] bits_q, bits_n;
  logic          any_evt;

  assign any_evt = |evt_i;

  always_comb begin
    mode_n = wr_i ? wdata_i[NC] : mode_q;
    if (!mode_q && any_evt) begin
      bits_n = evt_i;
    end else begin
      bits_n = evt_i | (wr_i ? (bits_q & wdata_i[NC-1:0]) : bits_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      bits_q <= '0;
    end else begin
      mode_q <= mode_n;
      bits_q <= bits_n;
    end
  end

  assign code_o = {mode_q, bits_q};

  // R7: latest-only mode keeps exactly the new pulse bits
  a_r7_latest_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_o[NC] && any_evt) |=> (code_o[NC-1:0] == $past(evt_i)));

  // R6: accumulate mode never loses a pulsed bit
  a_r6_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o[NC] && any_evt) |=> ((code_o[NC-1:0] & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/cec_cnt_hold.sv
// Holds an error count for readout.
module cec_cnt_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= d_i;
  end

  // R8: held count follows the input one cycle later
  a_r8_count_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q_o == $past(d_i)));
endmodule

// File: rtl/can_err_capture.sv
module can_err_capture
  import can_err_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLAG-1:0] fault_evt_i,
  input  logic [NCODE-1:0] code_evt_i,
  input  logic [DW-1:0]   tx_cnt_i,
  input  logic [DW-1:0]   rx_cnt_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            err_irq_o
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic wr_flag, wr_fen, wr_code, wr_ien;
  assign wr_flag = wr_en_i && (wr_addr_i == A_FLAG);
  assign wr_fen  = wr_en_i && (wr_addr_i == A_FEN);
  assign wr_code = wr_en_i && (wr_addr_i == A_CODE);
  assign wr_ien  = wr_en_i && (wr_addr_i == A_IEN);

  logic [NFLAG-1:0] flag_q;
  logic [NCODE:0]   code_q;
  logic [DW-1:0]    tx_q, rx_q;

  cec_w0c_bank #(.W(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n_s), .set_i(fault_evt_i),
    .wr_i(wr_flag), .wdata_i(wr_data_i[NFLAG-1:0]), .q_o(flag_q));

  cec_code_capture #(.NC(NCODE)) u_code (
    .clk(clk), .rst_n(rst_n_s), .evt_i(code_evt_i),
    .wr_i(wr_code), .wdata_i(wr_data_i[NCODE:0]), .code_o(code_q));

  cec_cnt_hold #(.W(DW)) u_tx (.clk(clk), .rst_n(rst_n_s), .d_i(tx_cnt_i), .q_o(tx_q));
  cec_cnt_hold #(.W(DW)) u_rx (.clk(clk), .rst_n(rst_n_s), .d_i(rx_cnt_i), .q_o(rx_q));

  // enable registers
  logic [NFLAG-1:0] fen_q, fen_n;
  logic             ien_q, ien_n;

  always_comb begin
    fen_n = wr_fen ? wr_data_i[NFLAG-1:0] : fen_q;
    ien_n = wr_ien ? wr_data_i[IRQ_BIT]   : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      fen_q <= '0;
      ien_q <= 1'b0;
    end else begin
      fen_q <= fen_n;
      ien_q <= ien_n;
    end
  end

  logic err_stat;
  assign err_stat  = |(flag_q & fen_q);
  assign err_irq_o = err_stat & ien_q;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_FLAG:  rd_data_o = flag_q;
      A_FEN:   rd_data_o = fen_q;
      A_CODE:  rd_data_o = code_q;
      A_TXCNT: rd_data_o = tx_q;
      A_RXCNT: rd_data_o = rx_q;
      A_ISTAT: rd_data_o[IRQ_BIT] = err_stat;
      A_IEN:   rd_data_o[IRQ_BIT] = ien_q;
      default: rd_data_o = '0;
    endcase
  end

  // R9: interrupt only from an enabled, latched flag
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_irq_o |-> ((flag_q & fen_q) != '0));

  // R10: interrupt gated by its enable bit
  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_irq_o |-> ien_q);

  // R11: nothing pending straight after reset release
  a_r11_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_s) |-> (!err_irq_o && flag_q == '0));
endmodule

// File: tb/can_err_capture_bench.sv
module can_err_capture_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] fault_evt = '0;
  logic [6:0] code_evt = '0;
  logic [7:0] tx_cnt = '0, rx_cnt = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       err_irq;

  always #2 clk = ~clk;

  can_err_capture u_can_err_capture (
    .clk(clk), .rst_n(rst_n), .fault_evt_i(fault_evt), .code_evt_i(code_evt),
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .err_irq_o(err_irq));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_flag = '0, m_en = '0, m_tx = '0, m_rx = '0;
  logic [6:0] m_code = '0;
  logic       m_mode = 1'b0, m_ie = 1'b0;

  function automatic logic [7:0] model_read(input logic [2:0] a);
    logic [7:0] r;
    r = '0;
    case (a)
      3'd0: r = m_flag;
      3'd1: r = m_en;
      3'd2: r = {m_mode, m_code};
      3'd3: r = m_tx;
      3'd4: r = m_rx;
      3'd5: r[5] = |(m_flag & m_en);
      3'd6: r[5] = m_ie;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string addr_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R1";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R8";
      3'd4: return "R8";
      3'd5: return "R9";
      3'd6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0] f_keep;
    logic [6:0] c_keep;
    logic       wf, wc;
    wf = wr_en && wr_addr == 3'd0;
    wc = wr_en && wr_addr == 3'd2;
    f_keep = wf ? (m_flag & wr_data) : m_flag;
    m_flag = fault_evt | f_keep;
    if (!m_mode && code_evt != '0) m_code = code_evt;
    else begin
      c_keep = wc ? (m_code & wr_data[6:0]) : m_code;
      m_code = code_evt | c_keep;
    end
    if (wc) m_mode = wr_data[7];
    if (wr_en && wr_addr == 3'd1) m_en = wr_data;
    if (wr_en && wr_addr == 3'd6) m_ie = wr_data[5];
    m_tx = tx_cnt;
    m_rx = rx_cnt;
  endtask

  // drive one cycle, check pre-edge read, then advance model
  task automatic step(input logic [7:0] fe, input logic [6:0] ce,
                      input logic [7:0] tx, input logic [7:0] rx,
                      input logic we, input logic [2:0] wa, input logic [7:0] wd,
                      input logic [2:0] ra, input string tag);
    @(negedge clk);
    fault_evt = fe; code_evt = ce; tx_cnt = tx; rx_cnt = rx;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    #1;
    check(tag, rd_data, model_read(ra));
    check("R10", {7'b0, err_irq}, {7'b0, m_ie & (|(m_flag & m_en))});
    model_step();
  endtask

  task automatic idle_read(input logic [2:0] ra, input string tag);
    step(8'h00, 7'h00, m_tx, m_rx, 1'b0, 3'd0, 8'h00, ra, tag);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7041));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R11: reset contents
    for (int a = 0; a < 8; a++) idle_read(3'(a), "R11");

    // R4: enable register write
    step(8'h00, 7'h00, 8'h00, 8'h00, 1'b1, 3'd1, 8'hA5, 3'd1, "R4");
    idle_read(3'd1, "R4");
    // R1: every fault class latches
    step(8'hFF, 7'h00, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 3'd0, "R1");
    idle_read(3'd0, "R1");
    // R2: written zero clears only that bit
    step(8'h00, 7'h00, 8'h00, 8'h00, 1'b1, 3'd0, 8'hFE, 3'd0, "R2");
    idle_read(3'd0, "R2");
    // R3: set beats clear in the same cycle
    step(8'h01, 7'h00, 8'h00, 8'h00, 1'b1, 3'd0, 8'h00, 3'd0, "R3");
    idle_read(3'd0, "R3");
    // R10 / R9: interrupt enable, status
    step(8'h00, 7'h00, 8'h00, 8'h00, 1'b1, 3'd6, 8'hFF, 3'd6, "R10");
    idle_read(3'd6, "R10");
    idle_read(3'd5, "R9");
    step(8'h00, 7'h00, 8'h00, 8'h00, 1'b1, 3'd5, 8'h00, 3'd5, "R9");
    idle_read(3'd5, "R9");
    // R5 / R6: accumulate mode
    step(8'h00, 7'h00, 8'h00, 8'h00, 1'b1, 3'd2, 8'h80, 3'd2, "R5");
    step(8'h00, 7'h01, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 3'd2, "R5");
    step(8'h00, 7'h08, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 3'd2, "R6");
    idle_read(3'd2, "R6");
    step(8'h00, 7'h00, 8'h00, 8'h00, 1'b1, 3'd2, 8'hFE, 3'd2, "R6");
    idle_read(3'd2, "R6");
    // R7: latest-only mode
    step(8'h00, 7'h00, 8'h00, 8'h00, 1'b1, 3'd2, 8'h00, 3'd2, "R7");
    step(8'h00, 7'h41, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 3'd2, "R7");
    step(8'h00, 7'h04, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 3'd2, "R7");
    step(8'h00, 7'h02, 8'h00, 8'h00, 1'b1, 3'd2, 8'h00, 3'd2, "R7");
    idle_read(3'd2, "R7");
    // R8: counters, write ignored
    step(8'h00, 7'h00, 8'h37, 8'hC2, 1'b1, 3'd3, 8'hFF, 3'd3, "R8");
    idle_read(3'd3, "R8");
    idle_read(3'd4, "R8");
    idle_read(3'd7, "R11");

    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] fe;
      logic [6:0] ce;
      logic [2:0] ra;
      fe = ($urandom % 4 == 0) ? 8'($urandom & $urandom & $urandom) : 8'h00;
      ce = ($urandom % 4 == 0) ? 7'($urandom & $urandom) : 7'h00;
      ra = 3'($urandom);
      step(fe, ce, 8'($urandom), 8'($urandom), ($urandom % 3 == 0),
           3'($urandom), 8'($urandom | $urandom), ra, addr_tag(ra));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule